// File: doc/BRIEF.md
# Dual Mailbox Register Interface

This block carries 32-bit messages between a host processor and a DSP through two one-way mailboxes. One mailbox carries mail from the DSP to the host and the other carries mail from the host to the DSP. Each side reaches the mailboxes through its own 16-bit register port, one strobe per access, and sees a window of 256 register offsets. Each mailbox takes two offsets, one for its high half and one for its low half. Bit 15 of the high half is the mail-valid flag. Writing the low half raises the flag, reading the low half drops it, and a write to the high half always stores the flag as zero.

The DSP port can also write an interrupt-request register. A request with bit 0 set sends a one-cycle pulse to the host. A request with bit 0 clear raises a sticky error flag instead. Both full mailbox words are also driven on peek outputs, so either side's logic can see them without changing any state. When both ports touch the same mailbox in one cycle, a fixed set of rules settles the result. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `dual_mailbox_regs`

## Requirements
- R1: After reset, both peek outputs are 0x00000000, `irq_pulse` is 0 and `irq_err` is 0.
- R2: A write to a high-half offset stores bits 14:0 of the written value, and bit 15 of the high half becomes 0.
- R3: A write to a low-half offset stores all 16 bits and sets bit 15 of that mailbox's high half on the same clock edge.
- R4: A read of a low-half offset returns the stored low value in the same cycle, and bit 15 of that mailbox's high half is clear after the clock edge.
- R5: A read of a high-half offset returns all 16 bits, including the flag, and changes no state.
- R6: Offsets 0xFC and 0xFD are the high and low halves of the DSP-to-host mailbox. Offsets 0xFE and 0xFF are the high and low halves of the host-to-DSP mailbox. Each peek output carries the high half in bits 31:16 and the low half in bits 15:0.
- R7: A DSP-port write to offset 0xFB with bit 0 set drives `irq_pulse` high for exactly the one cycle after the write edge.
- R8: A DSP-port write to offset 0xFB with bit 0 clear leaves `irq_pulse` low and sets `irq_err`, which stays set until reset.
- R9: If one port reads a low half in the same cycle that the other port writes that low half, the write wins: the new value is stored and the flag ends set. The read returns the old low value.
- R10: If both ports write the same half in one cycle, the DSP-port value is stored.
- R11: If a high half and the low half of the same mailbox are written in one cycle, the high half takes its new value with bit 15 set.
- R12: Offsets 0x00 to 0xFA, and 0xFB on reads, return 0x0000. Writes to them change nothing, and a host-port write to 0xFB raises neither `irq_pulse` nor `irq_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host-port access strobe |
| h_wr | input | 1 | Host-port write (1) or read (0) |
| h_addr | input | 8 | Host-port register offset |
| h_wdata | input | 16 | Host-port write data |
| h_rdata | output | 16 | Host-port read data (same cycle) |
| d_sel | input | 1 | DSP-port access strobe |
| d_wr | input | 1 | DSP-port write (1) or read (0) |
| d_addr | input | 8 | DSP-port register offset |
| d_wdata | input | 16 | DSP-port write data |
| d_rdata | output | 16 | DSP-port read data (same cycle) |
| d2h_peek | output | 32 | DSP-to-host mailbox word |
| h2d_peek | output | 32 | Host-to-DSP mailbox word |
| irq_pulse | output | 1 | One-cycle interrupt request to the host |
| irq_err | output | 1 | Sticky flag for a request written with bit 0 clear |

## Verification
A wrong flag or data register shows up on the peek outputs on the first edge after the access that corrupted it. It also shows in the read data of the next access to that offset, because reads are combinational. A wrong priority choice between the two ports shows up only in the cycle where both ports act together, so every collision rule is driven as its own directed cycle. A fault in the interrupt logic shows up on `irq_pulse` or `irq_err` one edge after the request write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned ADDR_W = 8;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned N_MBOX = 2;
  localparam int unsigned FLAG_B = DATA_W - 1;
  localparam logic [ADDR_W-1:0] IRQ_OFS  = 8'hFB;
  localparam logic [ADDR_W-1:0] MBOX_BASE = 8'hFC;
  localparam int unsigned P_HOST = 0;
  localparam int unsigned P_DSP  = 1;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             wr_hi,
  input  logic [1:0]             wr_lo,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic                   rd_lo,
  output logic [DATA_W-1:0]      hi_q,
  output logic [DATA_W-1:0]      lo_q
);
  logic [DATA_W-1:0] hi_d, lo_d, hi_src, lo_src;
  logic              upd;

  always_comb begin
    hi_src = wr_hi[P_DSP] ? wdata[P_DSP] : wdata[P_HOST];
    lo_src = wr_lo[P_DSP] ? wdata[P_DSP] : wdata[P_HOST];
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (|wr_hi) begin
      hi_d         = hi_src;
      hi_d[FLAG_B] = 1'b0;
    end
    if (rd_lo) hi_d[FLAG_B] = 1'b0;
    if (|wr_lo) begin
      lo_d         = lo_src;
      hi_d[FLAG_B] = 1'b1;
    end
    upd = (|wr_hi) | (|wr_lo) | rd_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (upd) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_lo) |=> hi_q[FLAG_B]);
  // R2
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_hi) && !(|wr_lo)) |=> !hi_q[FLAG_B]);
  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !(|wr_lo)) |=> !hi_q[FLAG_B]);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|wr_hi) && !(|wr_lo) && !rd_lo) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/mbx_irq_reg.sv
module mbx_irq_reg
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_bit,
  output logic irq_pulse,
  output logic irq_err
);
  logic pulse_d, err_d;

  always_comb begin
    pulse_d = req_wr & req_bit;
    err_d   = irq_err | (req_wr & ~req_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      irq_pulse <= pulse_d;
      irq_err   <= err_d;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |=> irq_err);
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && $rose(irq_err)));
endmodule

// File: rtl/dual_mailbox_regs.sv
module dual_mailbox_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              d_sel,
  input  logic              d_wr,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [DATA_W-1:0] d_rdata,
  output logic [2*DATA_W-1:0] d2h_peek,
  output logic [2*DATA_W-1:0] h2d_peek,
  output logic              irq_pulse,
  output logic              irq_err
);
  logic [1:0] rst_sync;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  logic [1:0]              p_sel, p_wr;
  logic [1:0][ADDR_W-1:0]  p_addr;
  logic [1:0][DATA_W-1:0]  p_wdata;
  logic [1:0][DATA_W-1:0]  p_rdata;
  logic [N_MBOX-1:0][DATA_W-1:0] mb_hi, mb_lo;

  assign p_sel   = {d_sel, h_sel};
  assign p_wr    = {d_wr, h_wr};
  assign p_addr  = {d_addr, h_addr};
  assign p_wdata = {d_wdata, h_wdata};

  for (genvar g = 0; g < N_MBOX; g++) begin : g_mbox
    localparam logic [ADDR_W-1:0] HI_OFS = MBOX_BASE + ADDR_W'(2*g);
    localparam logic [ADDR_W-1:0] LO_OFS = MBOX_BASE + ADDR_W'(2*g + 1);
    logic [1:0] wr_hi, wr_lo, rd_lo_p;
    for (genvar p = 0; p < 2; p++) begin : g_port
      assign wr_hi[p]   = p_sel[p] &  p_wr[p] & (p_addr[p] == HI_OFS);
      assign wr_lo[p]   = p_sel[p] &  p_wr[p] & (p_addr[p] == LO_OFS);
      assign rd_lo_p[p] = p_sel[p] & ~p_wr[p] & (p_addr[p] == LO_OFS);
    end
    mbx_slot u_slot (
      .clk   (clk),
      .rst_n (rst_ns),
      .wr_hi (wr_hi),
      .wr_lo (wr_lo),
      .wdata (p_wdata),
      .rd_lo (|rd_lo_p),
      .hi_q  (mb_hi[g]),
      .lo_q  (mb_lo[g])
    );
  end

  for (genvar p = 0; p < 2; p++) begin : g_rmux
    always_comb begin
      p_rdata[p] = '0;
      for (int m = 0; m < N_MBOX; m++) begin
        if (p_addr[p] == MBOX_BASE + ADDR_W'(2*m))     p_rdata[p] = mb_hi[m];
        if (p_addr[p] == MBOX_BASE + ADDR_W'(2*m + 1)) p_rdata[p] = mb_lo[m];
      end
    end
  end

  assign h_rdata  = p_rdata[P_HOST];
  assign d_rdata  = p_rdata[P_DSP];
  assign d2h_peek = {mb_hi[0], mb_lo[0]};
  assign h2d_peek = {mb_hi[1], mb_lo[1]};

  mbx_irq_reg u_irq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .req_wr    (d_sel & d_wr & (d_addr == IRQ_OFS)),
    .req_bit   (d_wdata[0]),
    .irq_pulse (irq_pulse),
    .irq_err   (irq_err)
  );

  // R12
  low_ofs_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (h_addr < MBOX_BASE) |-> (h_rdata == '0));
  // R6
  peek_match_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (d_addr == MBOX_BASE) |-> (d_rdata == d2h_peek[2*DATA_W-1:DATA_W]));
endmodule

// File: tb/dual_mailbox_regs_tb_top.sv
module dual_mailbox_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic h_sel, h_wr, d_sel, d_wr;
  logic [7:0]  h_addr, d_addr;
  logic [15:0] h_wdata, d_wdata, h_rdata, d_rdata;
  logic [31:0] d2h_peek, h2d_peek;
  logic irq_pulse, irq_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_mailbox_regs dut_i (.*);

  // {dsp_port, wr, addr, wdata, exp_rdata, exp_d2h, exp_h2d}
  localparam int NV = 13;
  localparam logic [105:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'hFC, 16'hFFFF, 16'h0000, 32'h7FFF_0000, 32'h0000_0000},
    {1'b1, 1'b0, 8'hFC, 16'h0000, 16'h7FFF, 32'h7FFF_0000, 32'h0000_0000},
    {1'b1, 1'b1, 8'hFD, 16'h1234, 16'h0000, 32'hFFFF_1234, 32'h0000_0000},
    {1'b0, 1'b0, 8'hFC, 16'h0000, 16'hFFFF, 32'hFFFF_1234, 32'h0000_0000},
    {1'b0, 1'b0, 8'hFD, 16'h0000, 16'h1234, 32'h7FFF_1234, 32'h0000_0000},
    {1'b0, 1'b0, 8'hFD, 16'h0000, 16'h1234, 32'h7FFF_1234, 32'h0000_0000},
    {1'b0, 1'b1, 8'hFE, 16'h8001, 16'h0000, 32'h7FFF_1234, 32'h0001_0000},
    {1'b0, 1'b1, 8'hFF, 16'hBEEF, 16'h0000, 32'h7FFF_1234, 32'h8001_BEEF},
    {1'b1, 1'b0, 8'hFE, 16'h0000, 16'h8001, 32'h7FFF_1234, 32'h8001_BEEF},
    {1'b1, 1'b0, 8'hFF, 16'h0000, 16'hBEEF, 32'h7FFF_1234, 32'h0001_BEEF},
    {1'b0, 1'b1, 8'h10, 16'hAAAA, 16'h0000, 32'h7FFF_1234, 32'h0001_BEEF},
    {1'b0, 1'b0, 8'h10, 16'h0000, 16'h0000, 32'h7FFF_1234, 32'h0001_BEEF},
    {1'b1, 1'b0, 8'hFB, 16'h0000, 16'h0000, 32'h7FFF_1234, 32'h0001_BEEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    h_sel = 0; h_wr = 0; h_addr = '0; h_wdata = '0;
    d_sel = 0; d_wr = 0; d_addr = '0; d_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 d2h", d2h_peek, 32'h0);
    chk("R1 h2d", h2d_peek, 32'h0);
    chk("R1 irq", {30'd0, irq_pulse, irq_err}, 32'h0);

    // vector walk: R2 R3 R4 R5 R6 R12
    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      v = VEC[i];
      idle();
      if (v[105]) begin
        d_sel = 1; d_wr = v[104]; d_addr = v[103:96]; d_wdata = v[95:80];
      end else begin
        h_sel = 1; h_wr = v[104]; h_addr = v[103:96]; h_wdata = v[95:80];
      end
      #1;
      if (!v[104]) chk($sformatf("R5/R4/R12 rdata vec%0d", i),
                       {16'd0, v[105] ? d_rdata : h_rdata}, {16'd0, v[79:64]});
      tick();
      chk($sformatf("R2/R3/R6 d2h vec%0d", i), d2h_peek, v[63:32]);
      chk($sformatf("R2/R3/R6 h2d vec%0d", i), h2d_peek, v[31:0]);
    end

    // R9 write-low beats read-low
    idle();
    d_sel = 1; d_wr = 1; d_addr = 8'hFD; d_wdata = 16'h2222;
    h_sel = 1; h_wr = 0; h_addr = 8'hFD;
    #1 chk("R9 old low read", {16'd0, h_rdata}, 32'h1234);
    tick();
    chk("R9 write wins", d2h_peek, 32'hFFFF_2222);

    // R10 both write same half
    idle();
    h_sel = 1; h_wr = 1; h_addr = 8'hFE; h_wdata = 16'h0100;
    d_sel = 1; d_wr = 1; d_addr = 8'hFE; d_wdata = 16'h0200;
    tick();
    chk("R10 dsp priority", h2d_peek, 32'h0200_BEEF);

    // R11 high and low in same cycle
    idle();
    d_sel = 1; d_wr = 1; d_addr = 8'hFC; d_wdata = 16'h0033;
    h_sel = 1; h_wr = 1; h_addr = 8'hFD; h_wdata = 16'h4444;
    tick();
    chk("R11 hi+lo", d2h_peek, 32'h8033_4444);

    // R7 interrupt pulse
    idle();
    d_sel = 1; d_wr = 1; d_addr = 8'hFB; d_wdata = 16'h0001;
    #1 chk("R7 no early pulse", {31'd0, irq_pulse}, 32'd0);
    @(posedge clk); #1;
    chk("R7 pulse", {30'd0, irq_pulse, irq_err}, 32'h2);
    idle();
    @(posedge clk); #1;
    chk("R7 pulse ends", {31'd0, irq_pulse}, 32'd0);
    @(negedge clk);

    // R12 host write to irq offset ignored
    idle();
    h_sel = 1; h_wr = 1; h_addr = 8'hFB; h_wdata = 16'h0001;
    @(posedge clk); #1;
    chk("R12 host irq ignored", {30'd0, irq_pulse, irq_err}, 32'h0);
    @(negedge clk);

    // R8 bad request
    idle();
    d_sel = 1; d_wr = 1; d_addr = 8'hFB; d_wdata = 16'h0002;
    @(posedge clk); #1;
    chk("R8 err set", {30'd0, irq_pulse, irq_err}, 32'h1);
    @(negedge clk);
    idle();
    repeat (3) tick();
    chk("R8 err sticky", {31'd0, irq_err}, 32'd1);

    // R1 reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset d2h", d2h_peek, 32'h0);
    chk("R1 reset err", {31'd0, irq_err}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule